// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend Controller

This block is the device-side clock-enable logic of a synchronous DRAM. On every rising clock edge it samples the clock-enable pin. From that sample it decides whether the internal clock runs in the following cycle, whether outputs and the burst address must hold their value, and whether the command path must discard its inputs. The current operating mode is reported on two status outputs, so a bench can tell the modes apart.

A low sample on the clock-enable pin has two possible meanings. The bank logic supplies an "all banks idle" status. If that status is true at the edge where the low level is first seen, the block enters power-down. Otherwise it enters a plain clock suspend. In both cases the edge that sees the low level still behaves as a normal edge, and the mode starts one cycle later. Leaving either mode is synchronous. The edge that samples the pin high is already a live edge and accepts a command.

The command path passes through the block. Whenever the internal clock is gated, the command path receives a configurable no-operation code in place of the incoming command.

Top module: `cke_suspend_ctrl`

## Requirements
- R1: After reset, the block is in the active mode: clk_en_o=1, suspend_o=0, pdown_o=0, freeze_o=0, ignore_o=0.
- R2: In the active mode, cke_i sampled low with banks_idle_i=0 leaves that edge live (clk_en_o=1, cmd_o=cmd_i) and sets suspend_o=1 and freeze_o=1 from the next cycle.
- R3: In the active mode, cke_i sampled low with banks_idle_i=1 leaves that edge live and sets pdown_o=1 and freeze_o=1 from the next cycle, with suspend_o=0.
- R4: In suspend or power-down with cke_i low, clk_en_o=0, ignore_o=1, and cmd_o equals the no-operation code NOP_CMD (default 4'hF).
- R5: While cke_i stays low, the mode holds, whatever value banks_idle_i takes.
- R6: In suspend or power-down, cke_i high makes clk_en_o=1 and cmd_o=cmd_i in that same cycle. The block is in the active mode after that edge.
- R7: suspend_o and pdown_o are never both high.
- R8: In the active mode, cmd_o follows cmd_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock-enable pin |
| banks_idle_i | input | 1 | All banks idle, from the bank logic |
| cmd_i | input | CMD_W | Incoming command code |
| clk_en_o | output | 1 | Internal clock qualifier for the current edge |
| freeze_o | output | 1 | Hold the output state and the burst address |
| ignore_o | output | 1 | Command path must drop its inputs |
| suspend_o | output | 1 | Clock suspend mode |
| pdown_o | output | 1 | Power-down mode |
| cmd_o | output | CMD_W | Command forwarded to the command path |

## Verification
The hardest cases to reach are the edges where the mode changes. These are the entry edge, which must still be live, and the exit edge, which must already be live. Each is only one cycle wide. The stimulus table switches cke_i between consecutive rows and samples just before each rising edge. One row pair holds suspend for a single cycle. Other rows toggle banks_idle_i while already suspended or powered down, which shows that the idle status matters only at entry. A directed test then applies reset while the block is in power-down.

// File: rtl/cke_pkg.sv
package cke_pkg;
  typedef enum logic [1:0] {
    CK_ACTIVE  = 2'd0,
    CK_SUSPEND = 2'd1,
    CK_PDOWN   = 2'd2
  } ck_mode_e;
endpackage

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
  import cke_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cke_i,
  input  logic     banks_idle_i,
  output ck_mode_e mode_o
);
  ck_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (cke_i) mode_d = CK_ACTIVE;
    else if (mode_q == CK_ACTIVE) mode_d = banks_idle_i ? CK_PDOWN : CK_SUSPEND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= CK_ACTIVE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_enter_susp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CK_ACTIVE && !cke_i && !banks_idle_i) |=> (mode_q == CK_SUSPEND));
  p_enter_pdown_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CK_ACTIVE && !cke_i && banks_idle_i) |=> (mode_q == CK_PDOWN));
  p_hold_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != CK_ACTIVE && !cke_i) |=> $stable(mode_q));
  p_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> (mode_q == CK_ACTIVE));
endmodule

// File: rtl/cke_gate.sv
module cke_gate
  import cke_pkg::*;
#(
  parameter int unsigned      CMD_W   = 4,
  parameter logic [CMD_W-1:0] NOP_CMD = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ck_mode_e         mode_i,
  input  logic             cke_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             clk_en_o,
  output logic             ignore_o,
  output logic             freeze_o,
  output logic             suspend_o,
  output logic             pdown_o,
  output logic [CMD_W-1:0] cmd_o
);
  logic live;

  // entry edge still live (mode not yet changed); exit edge live via cke_i
  assign live      = (mode_i == CK_ACTIVE) | cke_i;
  assign clk_en_o  = live;
  assign ignore_o  = ~live;
  assign freeze_o  = (mode_i != CK_ACTIVE);
  assign suspend_o = (mode_i == CK_SUSPEND);
  assign pdown_o   = (mode_i == CK_PDOWN);
  assign cmd_o     = live ? cmd_i : NOP_CMD;

  p_ignore_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_o && !cke_i) |-> (ignore_o && cmd_o == NOP_CMD));
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({suspend_o, pdown_o}));
  p_pass_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_o |-> (cmd_o == cmd_i && clk_en_o));
endmodule

// File: rtl/cke_suspend_ctrl.sv
module cke_suspend_ctrl
  import cke_pkg::*;
#(
  parameter int unsigned      CMD_W   = 4,
  parameter logic [CMD_W-1:0] NOP_CMD = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             banks_idle_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             clk_en_o,
  output logic             freeze_o,
  output logic             ignore_o,
  output logic             suspend_o,
  output logic             pdown_o,
  output logic [CMD_W-1:0] cmd_o
);
  ck_mode_e mode;

  cke_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_i        (cke_i),
    .banks_idle_i (banks_idle_i),
    .mode_o       (mode)
  );

  cke_gate #(.CMD_W(CMD_W), .NOP_CMD(NOP_CMD)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .cke_i     (cke_i),
    .cmd_i     (cmd_i),
    .clk_en_o  (clk_en_o),
    .ignore_o  (ignore_o),
    .freeze_o  (freeze_o),
    .suspend_o (suspend_o),
    .pdown_o   (pdown_o),
    .cmd_o     (cmd_o)
  );

  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!suspend_o && !pdown_o));
endmodule

// File: tb/sim_cke_suspend_ctrl.sv
module sim_cke_suspend_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_W = 4;
  localparam logic [3:0] NOP = 4'hF;
  localparam int NV = 13;

  // {cke, idle, cmd[4], exp_en, exp_susp, exp_pd, exp_cmd[4], req[4]}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,1'b0,4'h3, 1'b1,1'b0,1'b0,4'h3, 4'd8},
    {1'b0,1'b0,4'h5, 1'b1,1'b0,1'b0,4'h5, 4'd2},
    {1'b0,1'b1,4'h6, 1'b0,1'b1,1'b0,4'hF, 4'd5},
    {1'b0,1'b0,4'h2, 1'b0,1'b1,1'b0,4'hF, 4'd4},
    {1'b1,1'b0,4'h7, 1'b1,1'b1,1'b0,4'h7, 4'd6},
    {1'b1,1'b1,4'h1, 1'b1,1'b0,1'b0,4'h1, 4'd6},
    {1'b0,1'b1,4'h4, 1'b1,1'b0,1'b0,4'h4, 4'd3},
    {1'b0,1'b0,4'h8, 1'b0,1'b0,1'b1,4'hF, 4'd5},
    {1'b0,1'b1,4'h9, 1'b0,1'b0,1'b1,4'hF, 4'd4},
    {1'b1,1'b1,4'hA, 1'b1,1'b0,1'b1,4'hA, 4'd6},
    {1'b0,1'b0,4'hB, 1'b1,1'b0,1'b0,4'hB, 4'd2},
    {1'b1,1'b1,4'hC, 1'b1,1'b1,1'b0,4'hC, 4'd6},
    {1'b1,1'b0,4'h0, 1'b1,1'b0,1'b0,4'h0, 4'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, idle = 1'b0;
  logic [CMD_W-1:0] cmd = '0;
  logic en, frz, ign, susp, pd;
  logic [CMD_W-1:0] cmd_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_suspend_ctrl #(.CMD_W(CMD_W), .NOP_CMD(NOP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .banks_idle_i(idle),
    .cmd_i(cmd), .clk_en_o(en), .freeze_o(frz), .ignore_o(ign),
    .suspend_o(susp), .pdown_o(pd), .cmd_o(cmd_out)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act={en,frz,ign,susp,pd,cmd}=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] pack(logic e, logic s, logic p, logic [3:0] c);
    return {e, s | p, ~e, s, p, c};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cmd = 4'h2;
    #(CLK_PERIOD/2 - 1);
    check("R1", {en,frz,ign,susp,pd,cmd_out}, pack(1'b1,1'b0,1'b0,4'h2));
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cke = VEC[i][16]; idle = VEC[i][15]; cmd = VEC[i][14:11];
      #(CLK_PERIOD/2 - 1);
      check($sformatf("R%0d row%0d", VEC[i][3:0], i), {en,frz,ign,susp,pd,cmd_out},
            pack(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]));
      if (susp && pd) check("R7", 10'h3FF, 10'h000);
    end
    // R3 power-down entry then R1 reset while powered down
    @(negedge clk); cke = 1'b0; idle = 1'b1; cmd = 4'h6;
    @(negedge clk); idle = 1'b0; #1;
    check("R3 pd entered", {en,frz,ign,susp,pd,cmd_out}, pack(1'b0,1'b0,1'b1,NOP));
    rst_n = 1'b0; #1;
    check("R1 reset in pd", {en,frz,ign,susp,pd,cmd_out}, pack(1'b1,1'b0,1'b0,4'h6));
    @(negedge clk); rst_n = 1'b1; cke = 1'b1; cmd = 4'h9;
    #(CLK_PERIOD/2 - 1);
    check("R8 after reset", {en,frz,ign,susp,pd,cmd_out}, pack(1'b1,1'b0,1'b0,4'h9));
    // R4 suspend held several cycles with idle toggling (R5)
    @(negedge clk); cke = 1'b0; idle = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle = k[0]; cmd = 4'(k);
      #(CLK_PERIOD/2 - 1);
      check("R4/R5 long suspend", {en,frz,ign,susp,pd,cmd_out}, pack(1'b0,1'b1,1'b0,NOP));
    end
    @(negedge clk); cke = 1'b1; cmd = 4'h5;
    #(CLK_PERIOD/2 - 1);
    check("R6 exit long suspend", {en,frz,ign,susp,pd,cmd_out}, pack(1'b1,1'b1,1'b0,4'h5));
    @(negedge clk);
    check("R6 active after exit", {en,frz,ign,susp,pd,cmd_out}, pack(1'b1,1'b0,1'b0,4'h5));
    finish_run();
  end
endmodule